// File: doc/BRIEF.md
# Shadow Register Copy Sequencer

This block keeps eight registers of an always-on, slow domain in step with the shadow registers that the bus writes in the fast domain. Each shadowed register carries a stale flag. A bus write to a shadow raises its flag at once. A single sequencer then copies the flagged registers one at a time into the backing store. It lowers each flag only when that register's copy has completed.

The slow domain is modelled by a one-cycle tick strobe, and each copy lasts a fixed number of ticks. Software polls the stale field in the status word before it trusts a value, most often waiting for the seconds flag to drop before it reads the time. A rising edge on the force-update input marks every register stale, which makes the sequencer refresh the whole backing store.

Top module: `shadow_sync_seq`

## Requirements
- R1: While reset is held and right after it, the stale mask is 0x00, busy is 0, the status word is zero and every backing copy reads RST_VAL (default 0).
- R2: A write with `wr_en` high sets stale bit `wr_sel` in the cycle after the write. The index is 0..5 for the persistent registers 0..5, 6 for alarm and 7 for seconds, so a seconds write gives mask 0x80.
- R3: `stat_word` carries the stale mask at bits 23:16 (seconds at bit 23) and busy at bit 0. All other bits are zero.
- R4: When the sequencer is idle and the mask is non-zero, it starts copying the lowest-numbered stale register. Two flags never clear in the same cycle.
- R5: A copy completes on the COPY_TICKS-th slow tick (default 4) counted after it starts. On that edge the stale bit clears and the backing copy takes the shadow value. A flag never clears on a cycle without a tick.
- R6: A write to the register under copy, made while that copy runs, keeps its stale bit set when the copy ends. A second full copy then carries the newer value.
- R7: A 0-to-1 change of `force_upd` sets all eight stale bits (mask 0xFF) in the next cycle. Holding it high sets nothing more.
- R8: `busy` is 1 exactly when the stale mask is non-zero.
- R9: Slow ticks that arrive while the mask is zero leave the mask and every backing copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow write strobe |
| wr_sel | input | 3 | Index of the shadow being written |
| wr_data | input | DATA_W | Write data |
| slow_tick | input | 1 | One-cycle strobe standing for a slow-domain clock edge |
| force_upd | input | 1 | Force-update control; its rising edge marks all registers stale |
| rd_sel | input | 3 | Index of the backing copy to read |
| rd_data | output | DATA_W | Selected backing copy |
| stale_mask | output | 8 | Stale flags, bit index = register index |
| busy | output | 1 | Any register still stale |
| stat_word | output | 32 | Status word with the stale field at 23:16 and busy at bit 0 |

## Verification
The hardest case to reach is a write that lands on the very register being copied, while that copy is partway through its tick count. The stimulus has to know when the copy started, so the directed test first drains the queue. It then writes one register, waits the start-up cycle and feeds exactly two ticks before rewriting the same register. After that it checks that the flag survives the completion edge and that the second value ends up in the backing store. A long random phase with sparse ticks, frequent writes and occasional force-update edges then hits rewrites at every tick count, and the reference model checks them cycle by cycle.

// File: rtl/shadow_seq_pkg.sv
package shadow_seq_pkg;
  localparam int NUM_REGS  = 8;
  localparam int IDX_W     = 3;
  localparam int STALE_LSB = 16;
  localparam int STAT_W    = 32;

  typedef logic [NUM_REGS-1:0] mask_t;
  typedef logic [IDX_W-1:0]    idx_t;

  // Priority order of the copy: index 0 is copied first, seconds last.
  typedef enum logic [IDX_W-1:0] {
    REG_PERS0 = 3'd0,
    REG_PERS1 = 3'd1,
    REG_PERS2 = 3'd2,
    REG_PERS3 = 3'd3,
    REG_PERS4 = 3'd4,
    REG_PERS5 = 3'd5,
    REG_ALARM = 3'd6,
    REG_SECS  = 3'd7
  } reg_id_e;
endpackage

// File: rtl/stale_tracker.sv
module stale_tracker
  import shadow_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  idx_t  wr_sel,
  input  logic  force_upd,
  input  logic  clr_en,
  input  idx_t  clr_idx,
  output mask_t mask,
  output mask_t set_vec
);
  mask_t mask_q, mask_d;
  logic  force_q;
  logic  force_rise;
  mask_t clr_vec;

  always_comb begin
    force_rise = force_upd & ~force_q;
    set_vec    = '0;
    if (wr_en)      set_vec[wr_sel] = 1'b1;
    if (force_rise) set_vec = '1;
    clr_vec = '0;
    if (clr_en)     clr_vec[clr_idx] = 1'b1;
    mask_d = (mask_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      force_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      force_q <= force_upd;
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/copy_fsm.sv
module copy_fsm
  import shadow_seq_pkg::*;
#(
  parameter int COPY_TICKS = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  mask_t mask,
  input  mask_t set_vec,
  input  logic  slow_tick,
  output logic  copy_done,
  output idx_t  cur_idx,
  output logic  clr_en
);
  localparam int CNT_W = $clog2(COPY_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(COPY_TICKS - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  idx_t             idx_q, idx_d;
  logic             redo_q, redo_d;
  idx_t             pick;

  // Lowest set bit wins.
  always_comb begin
    pick = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (mask[i]) pick = IDX_W'(i);
    end
  end

  always_comb begin
    copy_done = active_q & slow_tick & (cnt_q == LAST_CNT);
    active_d  = active_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    redo_d    = redo_q;
    if (copy_done) begin
      active_d = 1'b0;
    end else if (!active_q && (|mask)) begin
      active_d = 1'b1;
      idx_d    = pick;
      cnt_d    = '0;
      redo_d   = 1'b0;
    end else if (active_q) begin
      if (slow_tick)       cnt_d  = cnt_q + 1'b1;
      if (set_vec[idx_q])  redo_d = 1'b1;
    end
    clr_en = copy_done & ~redo_q & ~set_vec[idx_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      redo_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      redo_q   <= redo_d;
    end
  end

  assign cur_idx = idx_q;
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_seq_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  idx_t              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              copy_done,
  input  idx_t              cur_idx,
  input  idx_t              rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] shadow_q  [NUM_REGS];
  logic [DATA_W-1:0] shadow_d  [NUM_REGS];
  logic [DATA_W-1:0] backing_q [NUM_REGS];
  logic [DATA_W-1:0] backing_d [NUM_REGS];

  always_comb begin
    for (int g = 0; g < NUM_REGS; g++) begin
      shadow_d[g]  = (wr_en && wr_sel == IDX_W'(g)) ? wr_data : shadow_q[g];
      backing_d[g] = (copy_done && cur_idx == IDX_W'(g)) ? shadow_q[g] : backing_q[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_REGS; g++) begin
        shadow_q[g]  <= RST_VAL;
        backing_q[g] <= RST_VAL;
      end
    end else begin
      for (int g = 0; g < NUM_REGS; g++) begin
        shadow_q[g]  <= shadow_d[g];
        backing_q[g] <= backing_d[g];
      end
    end
  end

  assign rd_data = backing_q[rd_sel];
endmodule

// File: rtl/shadow_sync_seq.sv
module shadow_sync_seq
  import shadow_seq_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                COPY_TICKS = 4,
  parameter logic [DATA_W-1:0] RST_VAL    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              slow_tick,
  input  logic              force_upd,
  input  logic [2:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        stale_mask,
  output logic              busy,
  output logic [31:0]       stat_word
);
  mask_t mask;
  mask_t set_vec;
  logic  copy_done;
  idx_t  cur_idx;
  logic  clr_en;

  stale_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .force_upd (force_upd),
    .clr_en    (clr_en),
    .clr_idx   (cur_idx),
    .mask      (mask),
    .set_vec   (set_vec)
  );

  copy_fsm #(.COPY_TICKS(COPY_TICKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask      (mask),
    .set_vec   (set_vec),
    .slow_tick (slow_tick),
    .copy_done (copy_done),
    .cur_idx   (cur_idx),
    .clr_en    (clr_en)
  );

  shadow_bank #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .copy_done (copy_done),
    .cur_idx   (cur_idx),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data)
  );

  always_comb begin
    stale_mask = mask;
    busy       = |mask;
    stat_word  = '0;
    stat_word[STALE_LSB +: NUM_REGS] = mask;
    stat_word[0] = busy;
  end
endmodule

// File: rtl/shadow_seq_chk.sv
module shadow_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic       slow_tick,
  input logic       force_upd,
  input logic [7:0] stale_mask,
  input logic       busy,
  input logic [31:0] stat_word
);
  // R2 / R6: a write always leaves its flag set on the next cycle
  a_r2_write_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> stale_mask[$past(wr_sel)]);

  // R7: a rising force edge marks every register stale
  a_r7_force_all: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_upd) |=> (stale_mask == 8'hFF));

  // R5: flags drop only on a tick edge
  a_r5_clear_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_tick |=> (($past(stale_mask) & ~stale_mask) == 8'h00));

  // R4: at most one flag drops per cycle
  a_r4_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones($past(stale_mask) & ~stale_mask) <= 1));

  // R8 / R3: the status word's busy bit tracks the field it carries
  a_r8_busy_field: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (stat_word[23:16] != 8'h00));
endmodule

bind shadow_sync_seq shadow_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .slow_tick  (slow_tick),
  .force_upd  (force_upd),
  .stale_mask (stale_mask),
  .busy       (busy),
  .stat_word  (stat_word)
);

// File: tb/shadow_sync_seq_test.sv
module shadow_sync_seq_test;
  localparam int NT = 4;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        slow_tick;
  logic        force_upd;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic [7:0]  stale_mask;
  logic        busy;
  logic [31:0] stat_word;

  int checks = 0;
  int errors = 0;

  shadow_sync_seq #(.DATA_W(32), .COPY_TICKS(NT), .RST_VAL(32'h0)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .slow_tick(slow_tick), .force_upd(force_upd),
    .rd_sel(rd_sel), .rd_data(rd_data), .stale_mask(stale_mask),
    .busy(busy), .stat_word(stat_word)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit [7:0]    m_mask;
  bit          m_act;
  int          m_cnt;
  int          m_idx;
  bit          m_redo;
  bit          m_fq;
  logic [31:0] m_sh [8];
  logic [31:0] m_bk [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_act = 0; m_cnt = 0; m_idx = 0; m_redo = 0; m_fq = 0;
      for (int k = 0; k < 8; k++) begin m_sh[k] = 0; m_bk[k] = 0; end
    end else begin
      bit [7:0] setv;
      bit [7:0] nmask;
      bit done;
      setv = 0;
      if (wr_en) setv[wr_sel] = 1;
      if (force_upd && !m_fq) setv = 8'hFF;
      done = m_act && slow_tick && (m_cnt == NT - 1);
      nmask = m_mask | setv;
      if (done && !m_redo && !setv[m_idx]) nmask[m_idx] = 0;
      if (done) begin
        m_bk[m_idx] = m_sh[m_idx];
        m_act = 0;
      end else if (!m_act && m_mask != 0) begin
        for (int k = 7; k >= 0; k--) if (m_mask[k]) m_idx = k;
        m_act = 1; m_cnt = 0; m_redo = 0;
      end else if (m_act) begin
        if (slow_tick) m_cnt++;
        if (setv[m_idx]) m_redo = 1;
      end
      if (wr_en) m_sh[wr_sel] = wr_data;
      m_mask = nmask;
      m_fq = force_upd;
    end
  end

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(stale_mask == m_mask, "R4 mask vs model", {24'h0, stale_mask}, {24'h0, m_mask});
      chk(busy == (m_mask != 0), "R8 busy vs model", {31'h0, busy}, {31'h0, m_mask != 0});
      chk(stat_word == {8'h0, m_mask, 15'h0, m_mask != 8'h0}, "R3 status vs model",
          stat_word, {8'h0, m_mask, 15'h0, m_mask != 8'h0});
      chk(rd_data == m_bk[rd_sel], "R5 backing vs model", rd_data, m_bk[rd_sel]);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input logic [31:0] d);
    wr_en = 1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      slow_tick = 1;
      @(negedge clk);
      slow_tick = 0;
      @(negedge clk);
    end
  endtask

  task automatic rd_chk(input int sel, input logic [31:0] exp, input string req);
    rd_sel = 3'(sel);
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    slow_tick = 0; force_upd = 0; rd_sel = 0;
    idle(3);
    // R1: reset state
    chk(stale_mask == 8'h00, "R1 mask in reset", {24'h0, stale_mask}, 32'h0);
    chk(busy == 1'b0, "R1 busy in reset", {31'h0, busy}, 32'h0);
    chk(stat_word == 32'h0, "R1 status in reset", stat_word, 32'h0);
    for (int k = 0; k < 8; k++) rd_chk(k, 32'h0, "R1 backing reset value");
    @(negedge clk);
    rst_n = 1;
    idle(2);
    chk(stale_mask == 8'h00, "R1 mask after release", {24'h0, stale_mask}, 32'h0);

    // R2 / R3: seconds write sets bit 7 and status bit 23
    wr(7, 32'hCAFE0007);
    chk(stale_mask == 8'h80, "R2 seconds flag", {24'h0, stale_mask}, 32'h80);
    chk(stat_word == 32'h0080_0001, "R3 status layout", stat_word, 32'h0080_0001);
    idle(2);
    ticks(NT - 1);
    chk(stale_mask == 8'h80, "R5 still stale before last tick", {24'h0, stale_mask}, 32'h80);
    ticks(1);
    chk(stale_mask == 8'h00, "R5 cleared on last tick", {24'h0, stale_mask}, 32'h0);
    chk(busy == 1'b0, "R8 idle after copy", {31'h0, busy}, 32'h0);
    rd_chk(7, 32'hCAFE0007, "R5 seconds backing updated");

    // R4: lowest stale register goes first
    wr(6, 32'hA1A1A1A1);
    wr(0, 32'h00000010);
    wr(5, 32'h00000055);
    chk(stale_mask == 8'h61, "R2 three flags", {24'h0, stale_mask}, 32'h61);
    idle(2);
    ticks(NT);
    chk(stale_mask == 8'h21, "R4 alarm copy done first", {24'h0, stale_mask}, 32'h21);
    idle(2);
    ticks(NT);
    chk(stale_mask == 8'h20, "R4 persistent0 before persistent5", {24'h0, stale_mask}, 32'h20);
    rd_chk(0, 32'h00000010, "R4 persistent0 backing");
    rd_chk(5, 32'h0, "R4 persistent5 not yet copied");
    idle(2);
    ticks(NT);
    chk(stale_mask == 8'h00, "R4 queue drained", {24'h0, stale_mask}, 32'h0);

    // R6: rewrite during copy repeats the copy
    wr(2, 32'h22220001);
    idle(2);
    ticks(2);
    wr(2, 32'h22220002);
    ticks(NT - 2);
    chk(stale_mask == 8'h04, "R6 flag survives completion", {24'h0, stale_mask}, 32'h04);
    idle(2);
    ticks(NT);
    chk(stale_mask == 8'h00, "R6 repeated copy done", {24'h0, stale_mask}, 32'h0);
    rd_chk(2, 32'h22220002, "R6 newer value copied");

    // R7: force edge marks all
    force_upd = 1;
    @(negedge clk);
    chk(stale_mask == 8'hFF, "R7 all stale", {24'h0, stale_mask}, 32'hFF);
    for (int k = 0; k < 8; k++) begin
      idle(2);
      ticks(NT);
    end
    chk(stale_mask == 8'h00, "R7 held high sets nothing more", {24'h0, stale_mask}, 32'h0);
    force_upd = 0;
    idle(2);

    // R9: ticks while idle change nothing
    ticks(10);
    chk(stale_mask == 8'h00, "R9 mask unchanged", {24'h0, stale_mask}, 32'h0);
    rd_chk(7, 32'hCAFE0007, "R9 seconds backing unchanged");
    rd_chk(2, 32'h22220002, "R9 persistent2 backing unchanged");

    // Random phase, model compared every cycle
    for (int c = 0; c < 4000; c++) begin
      wr_en     = ($urandom_range(0, 5) == 0);
      wr_sel    = 3'($urandom_range(0, 7));
      wr_data   = $urandom();
      slow_tick = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 150) == 0) force_upd = ~force_upd;
      rd_sel    = 3'($urandom_range(0, 7));
      @(negedge clk);
    end
    wr_en = 0; slow_tick = 0; force_upd = 0;
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule